// File: doc/BRIEF.md
# Row-Buffered SRAM Access Controller

This controller connects a 16-bit word bus to a banked SRAM array whose rows are eight words (128 bits) wide. The last row fetched from the array is held in a row-wide holding register with a tag and a valid flag. A read whose bank and row match the held row is served straight from that register. No decoder, word-line pulse or bank select is driven for such a read. Any other read opens the row with one read word-line pulse, reloads the holding register and returns the addressed word.

The array has no column multiplexer, so a store always rewrites a whole row. Each store is one read-then-write access. The controller fetches the row, replaces the target word, keeps the merged row in the holding register and writes it back. The read pulse, the gap between the pulses and the write pulse each last a number of clocks set by three margin inputs. The controller samples these inputs when it accepts the request. Three counters record full array reads, register-served reads and read-then-write accesses, so the decoder activity can be observed from outside.

Top module: `rbc_ctrl`

## Requirements
- R1: After reset `ready` is 1, `rdata_valid`, `rwl_en`, `wwl_en` and `bank_sel` are 0, and all three counters are 0. The holding register is invalid, so the first read is a full array read. The array contents are not cleared by reset.
- R2: The word address is split as bank = addr[10:9], row = addr[8:3] and word = addr[2:0]. While `rwl_en` or `wwl_en` is high, `bank_sel` has exactly bit `bank` set. Otherwise `bank_sel` is 0.
- R3: A read that misses drives `rwl_en` for rd_margin+1 cycles, starting in the cycle after acceptance, and holds `ready` low during that time. In the cycle after the pulse, `rdata_valid` is 1 for one cycle with the addressed word, `ready` returns to 1 and `full_rd_cnt` has grown by 1.
- R4: A read that hits (holding register valid, same bank and row) gives `rdata_valid` with the word in the cycle after acceptance. During that read `rwl_en`, `wwl_en` and `bank_sel` stay 0 and `ready` stays 1. `ler_cnt` grows by 1.
- R5: A store drives `rwl_en` for rd_margin+1 cycles. Then it waits gap_margin cycles with neither pulse, then drives `wwl_en` for wr_margin+1 cycles, and then returns `ready`. `war_cnt` grows by 1 and `rdata_valid` stays 0.
- R6: A store changes only the addressed word. The other seven words of the row keep their values, both in the holding register and in the array.
- R7: After a store, the holding register holds the merged row of that bank and row, so a read of any word in it is a hit that returns the updated data.
- R8: A read or store to another bank or row replaces the held row. A later read of the earlier row is then a miss.
- R9: `rwl_en` and `wwl_en` are never high together. Changing the margin inputs after acceptance does not change the pulse lengths of that access.
- R10: `req_valid` while `ready` is 0 is ignored. No counter moves, no data is returned and the held row is unchanged.
- R11: Hits may be accepted on consecutive cycles, each returning its word one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = read |
| req_addr | input | 11 | Word address {bank, row, word} |
| req_wdata | input | 16 | Store data |
| rd_margin | input | 4 | Read pulse length minus one, in cycles |
| gap_margin | input | 4 | Idle cycles between read and write pulses |
| wr_margin | input | 4 | Write pulse length minus one, in cycles |
| ready | output | 1 | Request is accepted in this cycle if present |
| rdata_valid | output | 1 | Read data valid |
| rdata | output | 16 | Read data |
| rwl_en | output | 1 | Read word-line pulse |
| wwl_en | output | 1 | Write word-line pulse |
| bank_sel | output | 4 | One-hot bank decode, active during pulses |
| full_rd_cnt | output | 16 | Full array reads |
| ler_cnt | output | 16 | Reads served from the holding register |
| war_cnt | output | 16 | Read-then-write accesses |

## Verification
The bench builds the block with its default parameters: four banks of 64 rows of eight 16-bit words, and 4-bit margins. With these values the two outermost banks and a row shared across them are both reachable, so a hit cannot be faked by matching the row alone. The full margin range from 0 to 15 is also reachable, including a gap of zero, which jumps straight from the read pulse to the write pulse. The bench changes every margin input right after acceptance, which exposes any late sampling of the margins.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RD   = 2'd1,
      PH_GAP  = 2'd2,
      PH_WR   = 2'd3
   } phase_e;

endpackage

// File: rtl/rbc_addr_dec.sv
module rbc_addr_dec #(
   parameter int BANKS         = 4,
   parameter int ROWS_PER_BANK = 64,
   parameter int WORDS_PER_ROW = 8,
   localparam int BANK_W = $clog2(BANKS),
   localparam int ROW_W  = $clog2(ROWS_PER_BANK),
   localparam int WSEL_W = $clog2(WORDS_PER_ROW),
   localparam int ADDR_W = BANK_W + ROW_W + WSEL_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] bank,
   output logic [ROW_W-1:0]  row,
   output logic [WSEL_W-1:0] word,
   input  logic              sel_en,
   input  logic [BANK_W-1:0] sel_bank,
   output logic [BANKS-1:0]  bank_sel
);

   assign word = addr[WSEL_W-1:0];
   assign row  = addr[WSEL_W +: ROW_W];
   assign bank = addr[ADDR_W-1 -: BANK_W];

   for (genvar b = 0; b < BANKS; b++) begin : g_bsel
      assign bank_sel[b] = sel_en && (sel_bank == BANK_W'(b));
   end

endmodule

// File: rtl/rbc_pulse_seq.sv
module rbc_pulse_seq
   import rbc_pkg::*;
#(
   parameter int MARGIN_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go_rd,
   input  logic                go_war,
   input  logic [MARGIN_W-1:0] rd_m,
   input  logic [MARGIN_W-1:0] gap_m,
   input  logic [MARGIN_W-1:0] wr_m,
   output logic                rwl_en,
   output logic                wwl_en,
   output logic                busy,
   output logic                rd_done,
   output logic                wr_done
);

   phase_e              ph;
   logic [MARGIN_W-1:0] cnt;
   logic [MARGIN_W-1:0] gap_q;
   logic [MARGIN_W-1:0] wr_q;
   logic                war_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph    <= PH_IDLE;
         cnt   <= '0;
         gap_q <= '0;
         wr_q  <= '0;
         war_q <= 1'b0;
      end else begin
         unique case (ph)
            PH_IDLE: begin
               if (go_rd || go_war) begin
                  ph    <= PH_RD;
                  cnt   <= rd_m;
                  gap_q <= gap_m;
                  wr_q  <= wr_m;
                  war_q <= go_war;
               end
            end
            PH_RD: begin
               if (cnt == '0) begin
                  if (!war_q) begin
                     ph <= PH_IDLE;
                  end else if (gap_q == '0) begin
                     ph  <= PH_WR;
                     cnt <= wr_q;
                  end else begin
                     ph  <= PH_GAP;
                     cnt <= gap_q - 1'b1;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_GAP: begin
               if (cnt == '0) begin
                  ph  <= PH_WR;
                  cnt <= wr_q;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_WR: begin
               if (cnt == '0) ph <= PH_IDLE;
               else           cnt <= cnt - 1'b1;
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign rwl_en  = (ph == PH_RD);
   assign wwl_en  = (ph == PH_WR);
   assign busy    = (ph != PH_IDLE);
   assign rd_done = rwl_en && (cnt == '0);
   assign wr_done = wwl_en && (cnt == '0);

endmodule

// File: rtl/rbc_row_latch.sv
module rbc_row_latch #(
   parameter int WORD_W        = 16,
   parameter int WORDS_PER_ROW = 8,
   parameter int TAG_W         = 8,
   localparam int LROW_W = WORD_W * WORDS_PER_ROW,
   localparam int WSEL_W = $clog2(WORDS_PER_ROW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              merge,
   input  logic [TAG_W-1:0]  ld_tag,
   input  logic [LROW_W-1:0] arr_row,
   input  logic [WSEL_W-1:0] ld_word,
   input  logic [WORD_W-1:0] wdata,
   input  logic [TAG_W-1:0]  q_tag,
   input  logic [WSEL_W-1:0] q_word,
   output logic              hit,
   output logic [WORD_W-1:0] q_data,
   output logic [LROW_W-1:0] row_q
);

   logic [LROW_W-1:0] merged;
   logic [TAG_W-1:0]  tag_q;
   logic              vld_q;

   for (genvar w = 0; w < WORDS_PER_ROW; w++) begin : g_merge
      assign merged[w*WORD_W +: WORD_W] =
         (merge && (ld_word == WSEL_W'(w))) ? wdata : arr_row[w*WORD_W +: WORD_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         tag_q <= '0;
         row_q <= '0;
      end else if (load) begin
         vld_q <= 1'b1;
         tag_q <= ld_tag;
         row_q <= merged;
      end
   end

   assign hit    = vld_q && (tag_q == q_tag);
   assign q_data = row_q[q_word*WORD_W +: WORD_W];

endmodule

// File: rtl/rbc_bank_array.sv
module rbc_bank_array #(
   parameter int WORD_W        = 16,
   parameter int WORDS_PER_ROW = 8,
   parameter int ROWS_PER_BANK = 64,
   parameter int BANKS         = 4,
   localparam int LROW_W = WORD_W * WORDS_PER_ROW,
   localparam int BANK_W = $clog2(BANKS),
   localparam int ROW_W  = $clog2(ROWS_PER_BANK)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [BANK_W-1:0] bank,
   input  logic [ROW_W-1:0]  row,
   input  logic [LROW_W-1:0] wr_row,
   output logic [LROW_W-1:0] rd_row
);

   logic [LROW_W-1:0] bank_rows [BANKS];

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic [LROW_W-1:0] mem [ROWS_PER_BANK];

      always_ff @(posedge clk) begin
         if (we && (bank == BANK_W'(b))) mem[row] <= wr_row;
      end

      assign bank_rows[b] = mem[row];
   end

   assign rd_row = bank_rows[bank];

endmodule

// File: rtl/rbc_ctrl.sv
module rbc_ctrl #(
   parameter int WORD_W        = 16,
   parameter int WORDS_PER_ROW = 8,
   parameter int ROWS_PER_BANK = 64,
   parameter int BANKS         = 4,
   parameter int MARGIN_W      = 4,
   parameter int CNT_W         = 16,
   localparam int BANK_W = $clog2(BANKS),
   localparam int ROW_W  = $clog2(ROWS_PER_BANK),
   localparam int WSEL_W = $clog2(WORDS_PER_ROW),
   localparam int ADDR_W = BANK_W + ROW_W + WSEL_W,
   localparam int TAG_W  = BANK_W + ROW_W,
   localparam int LROW_W = WORD_W * WORDS_PER_ROW
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [WORD_W-1:0]   req_wdata,
   input  logic [MARGIN_W-1:0] rd_margin,
   input  logic [MARGIN_W-1:0] gap_margin,
   input  logic [MARGIN_W-1:0] wr_margin,
   output logic                ready,
   output logic                rdata_valid,
   output logic [WORD_W-1:0]   rdata,
   output logic                rwl_en,
   output logic                wwl_en,
   output logic [BANKS-1:0]    bank_sel,
   output logic [CNT_W-1:0]    full_rd_cnt,
   output logic [CNT_W-1:0]    ler_cnt,
   output logic [CNT_W-1:0]    war_cnt
);

   if (BANKS < 2 || (1 << BANK_W) != BANKS) begin : g_bad_banks
      $error("BANKS must be a power of two, at least 2");
   end
   if (ROWS_PER_BANK < 2 || (1 << ROW_W) != ROWS_PER_BANK) begin : g_bad_rows
      $error("ROWS_PER_BANK must be a power of two, at least 2");
   end
   if (WORDS_PER_ROW < 2 || (1 << WSEL_W) != WORDS_PER_ROW) begin : g_bad_words
      $error("WORDS_PER_ROW must be a power of two, at least 2");
   end
   if (MARGIN_W < 1 || CNT_W < 1 || WORD_W < 1) begin : g_bad_widths
      $error("widths must be positive");
   end

   logic [BANK_W-1:0] a_bank;
   logic [ROW_W-1:0]  a_row;
   logic [WSEL_W-1:0] a_word;
   logic [BANK_W-1:0] bank_q;
   logic [ROW_W-1:0]  row_q;
   logic [WSEL_W-1:0] word_q;
   logic [WORD_W-1:0] wdata_q;
   logic              war_q;
   logic              busy, rd_done, wr_done;
   logic              lat_hit;
   logic [WORD_W-1:0] lat_word;
   logic [LROW_W-1:0] lat_row;
   logic [LROW_W-1:0] arr_row;
   logic              accept, acc_hit, acc_miss, acc_war;

   rbc_addr_dec #(
      .BANKS(BANKS), .ROWS_PER_BANK(ROWS_PER_BANK), .WORDS_PER_ROW(WORDS_PER_ROW)
   ) i_dec (
      .addr(req_addr), .bank(a_bank), .row(a_row), .word(a_word),
      .sel_en(rwl_en || wwl_en), .sel_bank(bank_q), .bank_sel(bank_sel)
   );

   assign ready    = !busy;
   assign accept   = req_valid && ready;
   assign acc_war  = accept && req_write;
   assign acc_hit  = accept && !req_write && lat_hit;
   assign acc_miss = accept && !req_write && !lat_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q  <= '0;
         row_q   <= '0;
         word_q  <= '0;
         wdata_q <= '0;
         war_q   <= 1'b0;
      end else if (acc_war || acc_miss) begin
         bank_q  <= a_bank;
         row_q   <= a_row;
         word_q  <= a_word;
         wdata_q <= req_wdata;
         war_q   <= req_write;
      end
   end

   rbc_pulse_seq #(.MARGIN_W(MARGIN_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .go_rd(acc_miss), .go_war(acc_war),
      .rd_m(rd_margin), .gap_m(gap_margin), .wr_m(wr_margin),
      .rwl_en(rwl_en), .wwl_en(wwl_en), .busy(busy),
      .rd_done(rd_done), .wr_done(wr_done)
   );

   rbc_bank_array #(
      .WORD_W(WORD_W), .WORDS_PER_ROW(WORDS_PER_ROW),
      .ROWS_PER_BANK(ROWS_PER_BANK), .BANKS(BANKS)
   ) i_arr (
      .clk(clk), .we(wr_done), .bank(bank_q), .row(row_q),
      .wr_row(lat_row), .rd_row(arr_row)
   );

   rbc_row_latch #(
      .WORD_W(WORD_W), .WORDS_PER_ROW(WORDS_PER_ROW), .TAG_W(TAG_W)
   ) i_lat (
      .clk(clk), .rst_n(rst_n), .load(rd_done), .merge(war_q),
      .ld_tag({bank_q, row_q}), .arr_row(arr_row), .ld_word(word_q),
      .wdata(wdata_q), .q_tag({a_bank, a_row}), .q_word(a_word),
      .hit(lat_hit), .q_data(lat_word), .row_q(lat_row)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_valid <= 1'b0;
         rdata       <= '0;
      end else begin
         rdata_valid <= acc_hit || (rd_done && !war_q);
         if (acc_hit)                rdata <= lat_word;
         else if (rd_done && !war_q) rdata <= arr_row[word_q*WORD_W +: WORD_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_rd_cnt <= '0;
         ler_cnt     <= '0;
         war_cnt     <= '0;
      end else begin
         if (acc_miss) full_rd_cnt <= full_rd_cnt + 1'b1;
         if (acc_hit)  ler_cnt     <= ler_cnt + 1'b1;
         if (acc_war)  war_cnt     <= war_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/rbc_ctrl_chk.sv
module rbc_ctrl_chk #(
   parameter int BANKS = 4,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_write,
   input logic             ready,
   input logic             rdata_valid,
   input logic             rwl_en,
   input logic             wwl_en,
   input logic [BANKS-1:0] bank_sel,
   input logic             lat_hit,
   input logic [CNT_W-1:0] full_rd_cnt,
   input logic [CNT_W-1:0] ler_cnt,
   input logic [CNT_W-1:0] war_cnt
);

   a_r9_wl_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rwl_en && wwl_en));

   a_r2_bank_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_sel));

   a_r2_bank_when_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (rwl_en || wwl_en) |-> (bank_sel != '0));

   a_r2_bank_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(rwl_en || wwl_en) |-> (bank_sel == '0));

   a_r4_hit_no_array: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ready && !req_write && lat_hit)
      |=> (rdata_valid && !rwl_en && !wwl_en && ready));

   a_r5_store_opens_read: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ready && req_write) |=> (rwl_en && !ready));

   a_r5_no_data_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      wwl_en |-> !rdata_valid);

   a_r10_busy_during_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (rwl_en || wwl_en) |-> !ready);

   a_r10_full_cnt_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && ready && !req_write && !lat_hit) |=> $stable(full_rd_cnt));

   a_r10_ler_cnt_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && ready && !req_write && lat_hit) |=> $stable(ler_cnt));

   a_r10_war_cnt_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && ready && req_write) |=> $stable(war_cnt));

endmodule

bind rbc_ctrl rbc_ctrl_chk #(.BANKS(BANKS), .CNT_W(CNT_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .ready(ready), .rdata_valid(rdata_valid), .rwl_en(rwl_en), .wwl_en(wwl_en),
   .bank_sel(bank_sel), .lat_hit(lat_hit), .full_rd_cnt(full_rd_cnt),
   .ler_cnt(ler_cnt), .war_cnt(war_cnt)
);

// File: tb/test_rbc_ctrl.sv
module test_rbc_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [10:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [3:0]  rd_margin = '0, gap_margin = '0, wr_margin = '0;
   logic        ready, rdata_valid, rwl_en, wwl_en;
   logic [15:0] rdata;
   logic [3:0]  bank_sel;
   logic [15:0] full_rd_cnt, ler_cnt, war_cnt;

   always #2.5 clk = ~clk;

   rbc_ctrl i_rbc_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_margin(rd_margin),
      .gap_margin(gap_margin), .wr_margin(wr_margin), .ready(ready),
      .rdata_valid(rdata_valid), .rdata(rdata), .rwl_en(rwl_en), .wwl_en(wwl_en),
      .bank_sel(bank_sel), .full_rd_cnt(full_rd_cnt), .ler_cnt(ler_cnt),
      .war_cnt(war_cnt)
   );

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // bench model, built from the requirements
   logic [15:0] sh [2048];
   bit          m_vld = 1'b0;
   logic [7:0]  m_tag = '0;
   int          e_full = 0, e_ler = 0, e_war = 0;

   // {write, addr[10:0], data[15:0], rd_m, gap_m, wr_m}
   localparam int NV = 23;
   localparam logic [39:0] VEC [NV] = '{
      {1'b1, 11'h028, 16'hA000, 4'd0,  4'd0,  4'd0},
      {1'b1, 11'h029, 16'hA001, 4'd1,  4'd2,  4'd0},
      {1'b1, 11'h02A, 16'hA002, 4'd0,  4'd1,  4'd3},
      {1'b1, 11'h02B, 16'hA003, 4'd2,  4'd0,  4'd1},
      {1'b1, 11'h02C, 16'hA004, 4'd0,  4'd0,  4'd0},
      {1'b1, 11'h02D, 16'hA005, 4'd15, 4'd15, 4'd15},
      {1'b1, 11'h02E, 16'hA006, 4'd0,  4'd0,  4'd0},
      {1'b1, 11'h02F, 16'hA007, 4'd1,  4'd0,  4'd2},
      {1'b1, 11'h628, 16'hB3C0, 4'd0,  4'd0,  4'd0},
      {1'b1, 11'h62B, 16'hB3C3, 4'd0,  4'd2,  4'd0},
      {1'b0, 11'h02C, 16'h0000, 4'd15, 4'd0,  4'd0},
      {1'b0, 11'h028, 16'h0000, 4'd3,  4'd0,  4'd0},
      {1'b0, 11'h02F, 16'h0000, 4'd0,  4'd0,  4'd0},
      {1'b0, 11'h62B, 16'h0000, 4'd0,  4'd0,  4'd0},
      {1'b1, 11'h02A, 16'h5A5A, 4'd1,  4'd1,  4'd1},
      {1'b0, 11'h02A, 16'h0000, 4'd2,  4'd0,  4'd0},
      {1'b0, 11'h029, 16'h0000, 4'd0,  4'd0,  4'd0},
      {1'b0, 11'h02B, 16'h0000, 4'd0,  4'd0,  4'd0},
      {1'b0, 11'h628, 16'h0000, 4'd2,  4'd0,  4'd0},
      {1'b0, 11'h02E, 16'h0000, 4'd1,  4'd0,  4'd0},
      {1'b0, 11'h02A, 16'h0000, 4'd0,  4'd0,  4'd0},
      {1'b0, 11'h628, 16'h0000, 4'd0,  4'd0,  4'd0},
      {1'b0, 11'h02A, 16'h0000, 4'd4,  4'd0,  4'd0}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_cnt(input string req);
      chk(full_rd_cnt == 16'(e_full), req, "full_rd_cnt", full_rd_cnt, e_full);
      chk(ler_cnt == 16'(e_ler), req, "ler_cnt", ler_cnt, e_ler);
      chk(war_cnt == 16'(e_war), req, "war_cnt", war_cnt, e_war);
   endtask

   // issue one access, measure pulses at negedges, compare to the model
   task automatic run_op(input bit wr, input logic [10:0] a, input logic [15:0] d,
                         input logic [3:0] rm, input logic [3:0] gm,
                         input logic [3:0] wm, input bit hold_req);
      bit exp_hit;
      int n_rd = 0, n_gap = 0, n_wr = 0, bad_bank = 0, guard = 0;
      exp_hit = !wr && m_vld && (m_tag == a[10:3]);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      rd_margin = rm; gap_margin = gm; wr_margin = wm;
      @(negedge clk);
      // R9: margins changed after acceptance must not matter
      rd_margin = ~rm; gap_margin = ~gm; wr_margin = ~wm;
      if (hold_req) begin
         // R10: a miss read to another bank offered while busy
         req_write = 1'b0; req_addr = 11'h7F8;
      end else begin
         req_valid = 1'b0;
      end
      while (!ready && guard < 200) begin
         guard++;
         if (rwl_en) begin
            n_rd++;
            if (n_gap != 0 || n_wr != 0) bad_bank++;
         end else if (wwl_en) n_wr++;
         else n_gap++;
         if ((rwl_en || wwl_en) && bank_sel != (4'b1 << a[10:9])) bad_bank++;
         if (!(rwl_en || wwl_en) && bank_sel != 4'b0) bad_bank++;
         if (rdata_valid) bad_bank++;
         @(negedge clk);
      end
      req_valid = 1'b0;
      chk(bad_bank == 0, "R2", "bank_sel/order errors", bad_bank, 0);
      if (wr) begin
         chk(n_rd == int'(rm) + 1, "R5", "read pulse cycles", n_rd, int'(rm) + 1);
         chk(n_gap == int'(gm), "R5", "gap cycles", n_gap, int'(gm));
         chk(n_wr == int'(wm) + 1, "R5", "write pulse cycles", n_wr, int'(wm) + 1);
         chk(!rdata_valid, "R5", "rdata_valid after store", rdata_valid, 0);
         sh[a] = d;
         e_war++;
      end else if (exp_hit) begin
         chk(n_rd == 0 && n_wr == 0 && n_gap == 0, "R4", "busy cycles on hit",
             n_rd + n_wr + n_gap, 0);
         chk(rdata_valid && rdata == sh[a], "R4", "hit data", rdata, sh[a]);
         e_ler++;
      end else begin
         chk(n_rd == int'(rm) + 1 && n_wr == 0 && n_gap == 0, "R3",
             "miss pulse cycles", n_rd, int'(rm) + 1);
         chk(rdata_valid && rdata == sh[a], "R3", "miss data", rdata, sh[a]);
         e_full++;
      end
      m_vld = 1'b1;
      m_tag = a[10:3];
      chk_cnt(wr ? "R5" : (exp_hit ? "R4" : "R3"));
   endtask

   initial begin
      for (int i = 0; i < 2048; i++) sh[i] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(ready && !rdata_valid && !rwl_en && !wwl_en && bank_sel == 0, "R1",
          "idle outputs in reset", {ready, rdata_valid, rwl_en, wwl_en}, 4'b1000);
      rst_n = 1'b1;
      @(negedge clk);
      chk_cnt("R1");

      // vector table: R2 R3 R4 R5 R6 R7 R8 R9
      for (int v = 0; v < NV; v++) begin
         run_op(VEC[v][39], VEC[v][38:28], VEC[v][27:12],
                VEC[v][11:8], VEC[v][7:4], VEC[v][3:0], 1'b0);
      end

      // R10: request held high during a store is ignored
      run_op(1'b1, 11'h02F, 16'h7777, 4'd3, 4'd3, 4'd3, 1'b1);
      chk(!rdata_valid, "R10", "no data for ignored request", rdata_valid, 0);
      run_op(1'b0, 11'h02F, 16'h0, 4'd0, 4'd0, 4'd0, 1'b0);
      chk(rdata == 16'h7777, "R10", "held row kept after ignored request", rdata, 16'h7777);

      // R11: consecutive hits, one per cycle
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 11'h029;
      @(negedge clk);
      chk(rdata_valid && rdata == sh[11'h029], "R11", "first back-to-back hit",
          rdata, sh[11'h029]);
      req_addr = 11'h02D;
      @(negedge clk);
      req_valid = 1'b0;
      chk(rdata_valid && rdata == sh[11'h02D], "R11", "second back-to-back hit",
          rdata, sh[11'h02D]);
      chk(!rwl_en && ready, "R11", "no array access on hits", rwl_en, 0);
      e_ler += 2;
      chk_cnt("R11");

      // R1: reset invalidates the held row but keeps the array
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      m_vld = 1'b0; e_full = 0; e_ler = 0; e_war = 0;
      chk_cnt("R1");
      run_op(1'b0, 11'h02A, 16'h0, 4'd0, 4'd0, 4'd0, 1'b0);
      chk(full_rd_cnt == 16'd1, "R1", "first read after reset is full", full_rd_cnt, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule